// File: doc/BRIEF.md
# Stereo Attenuator with Ramped Mute

This block scales a stereo pair of 20-bit signed samples by a gain chosen from a 6-bit attenuation code. The code steps in 1 dB increments down to full silence. A mute request does not silence the output at once. Instead it moves a second gain factor from unity to zero in equal steps, one step per sample, and moves it back the same way when the request drops.

A table that is computed when the design is built turns each code into an unsigned coefficient with 15 fractional bits. A single multiplier is shared in time. It first combines the table coefficient with the mute factor into one effective gain, then applies that gain to the left sample and then to the right sample. Each product is rounded and clamped to 20 signed bits. Samples arrive as one-cycle strobes, at least four clock cycles apart. De-emphasis is not part of this block, and the path carries no such filter.

The sequencer has four states:
- Idle: waits for a sample strobe.
- Gain: forms the effective gain.
- Left: scales the left sample.
- Right: scales the right sample and publishes both results.

Its transitions are Idle to Gain when a strobe is accepted, then Gain to Left, Left to Right and Right to Idle, each unconditional.

Top module: `stereo_vol_mute`

## Requirements
- R1: Codes 0 and 1 apply unity gain, so the outputs equal the inputs, including the extremes 524287 and -524288.
- R2: A code n from 2 to 61 attenuates by n-1 dB.
  - Its coefficient is round(32768 * 10^(-(n-1)/20)).
  - The effective gain is floor((coef * mute_gain + 16384) / 32768).
  - Each output is floor((sample * gain + 16384) / 32768), clamped to the signed 20-bit range.
- R3: Codes 62 and 63 give coefficient 0, so both outputs are 0 for any sample.
- R4: `res_valid` is high for exactly one cycle, three rising edges after the edge that accepted the strobe. Both result ports update together on that edge and hold their values until the next result.
- R5: While `mute_req` is 1, each accepted sample uses the current mute gain. The gain then falls by 2048 toward 0, so the k-th muted sample (counting from 0, starting at unity) uses max(0, 32768 - 2048k), and the output is 0 from k = 16 on.
- R6: While `mute_req` is 0, each accepted sample uses the current mute gain. The gain then rises by 2048, up to 32768, starting from wherever a previous ramp left it.
- R7: The attenuation code and the mute request are sampled only on the accepting edge. Changes made while a sample is being processed do not affect that sample.
- R8: A strobe that arrives outside Idle is ignored. It produces no result and does not step the mute gain.
- R9: After reset both result ports are 0, `res_valid` is 0, and the mute gain is unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| smp_left | input | 20 | Left sample, signed |
| smp_right | input | 20 | Right sample, signed |
| atten_code | input | 6 | Attenuation code, 1 dB per step above code 1 |
| mute_req | input | 1 | 1 ramps toward silence, 0 ramps back to unity |
| res_valid | output | 1 | One-cycle pulse when results are updated |
| res_left | output | 20 | Scaled left sample, signed |
| res_right | output | 20 | Scaled right sample, signed |

## Verification
Two functions can act on the same accepting edge: a new attenuation code being latched, and a mute ramp step. The bench changes the code and raises the mute request on the same sample. It then requires that sample to use the new coefficient combined with the mute gain from before the step, and the following sample to use the stepped gain. A second clash arises when a strobe arrives while the multiplier is busy. The bench raises a mute request together with that ignored strobe, then proves through the next result's gain that the ramp did not move.

// File: rtl/volctl_pkg.sv
package volctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAIN,
        ST_LEFT,
        ST_RIGHT
    } vol_state_e;

    // Linear coefficient for an attenuation code, with frac fractional bits.
    // Uses repeated multiplication by 10^(-1/20) at 32-bit fixed point.
    function automatic int unsigned gain_of(input int n, input int codes, input int frac);
        longint unsigned acc;
        if (n <= 1) return (32'd1 << frac);
        if (n >= codes - 2) return 32'd0;
        acc = 64'd1 << 32;
        for (int i = 1; i < n; i++) begin
            acc = (acc * 64'd891250938 + 64'd500000000) / 64'd1000000000;
        end
        return 32'((acc + (64'd1 << (31 - frac))) >> (32 - frac));
    endfunction

endpackage

// File: rtl/volctl_gain_rom.sv
module volctl_gain_rom #(
    parameter int CODE_W    = 6,
    parameter int COEF_FRAC = 15
) (
    input  logic [CODE_W-1:0]  code,
    output logic [COEF_FRAC:0] coef
);
    import volctl_pkg::*;

    localparam int CODES  = 1 << CODE_W;
    localparam int COEF_W = COEF_FRAC + 1;

    logic [COEF_W-1:0] tab [CODES];

    for (genvar g = 0; g < CODES; g++) begin : g_entry
        assign tab[g] = COEF_W'(gain_of(g, CODES, COEF_FRAC));
    end

    assign coef = tab[code];

endmodule

// File: rtl/volctl_mute_ramp.sv
module volctl_mute_ramp #(
    parameter int COEF_FRAC = 15,
    parameter int RAMP_LOG2 = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               mute_req,
    output logic [COEF_FRAC:0] gain
);
    localparam int                   COEF_W = COEF_FRAC + 1;
    localparam logic [COEF_W-1:0]    UNITY  = COEF_W'(1) << COEF_FRAC;
    localparam logic [COEF_W-1:0]    STEP   = UNITY >> RAMP_LOG2;

    logic [COEF_W-1:0] gain_q;
    logic [COEF_W:0]   up_sum;

    assign up_sum = {1'b0, gain_q} + {1'b0, STEP};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= UNITY;
        end else if (step_en) begin
            if (mute_req) begin
                gain_q <= (gain_q >= STEP) ? gain_q - STEP : '0;
            end else begin
                gain_q <= (up_sum >= {1'b0, UNITY}) ? UNITY : up_sum[COEF_W-1:0];
            end
        end
    end

    assign gain = gain_q;

    // R5: the mute factor never exceeds unity
    assert_ramp_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= UNITY);

    // R5: a step while muting never raises the factor
    assert_ramp_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mute_req) |=> gain_q <= $past(gain_q));

    // R6: a step while unmuted never lowers the factor
    assert_ramp_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !mute_req) |=> gain_q >= $past(gain_q));

endmodule

// File: rtl/volctl_mac.sv
module volctl_mac #(
    parameter int DATA_W    = 20,
    parameter int COEF_FRAC = 15
) (
    input  logic signed [DATA_W:0]   op_a,
    input  logic        [COEF_FRAC:0] op_b,
    output logic signed [DATA_W-1:0] result
);
    localparam int PW = DATA_W + COEF_FRAC + 3;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (COEF_FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DATA_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = op_a * $signed({1'b0, op_b});
        shifted = (prod + HALF) >>> COEF_FRAC;
        if (shifted > MAXV) begin
            result = MAXV[DATA_W-1:0];
        end else if (shifted < MINV) begin
            result = MINV[DATA_W-1:0];
        end else begin
            result = shifted[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/stereo_vol_mute.sv
module stereo_vol_mute #(
    parameter int DATA_W    = 20,
    parameter int CODE_W    = 6,
    parameter int COEF_FRAC = 15,
    parameter int RAMP_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_left,
    input  logic signed [DATA_W-1:0] smp_right,
    input  logic [CODE_W-1:0]        atten_code,
    input  logic                     mute_req,
    output logic                     res_valid,
    output logic signed [DATA_W-1:0] res_left,
    output logic signed [DATA_W-1:0] res_right
);
    import volctl_pkg::*;

    localparam int COEF_W = COEF_FRAC + 1;
    localparam int PAD_W  = DATA_W + 1 - COEF_W;

    vol_state_e state_q, state_d;

    logic                     accept;
    logic [COEF_W-1:0]        table_coef;
    logic [COEF_W-1:0]        mute_gain;
    logic [COEF_W-1:0]        coef_q;
    logic [COEF_W-1:0]        mg_q;
    logic [COEF_W-1:0]        eff_q;
    logic signed [DATA_W-1:0] smp_l_q, smp_r_q, left_hold_q;
    logic signed [DATA_W:0]   mac_a;
    logic [COEF_W-1:0]        mac_b;
    logic signed [DATA_W-1:0] mac_res;

    assign accept = smp_valid && (state_q == ST_IDLE);

    volctl_gain_rom #(.CODE_W(CODE_W), .COEF_FRAC(COEF_FRAC)) u_rom (
        .code (atten_code),
        .coef (table_coef)
    );

    volctl_mute_ramp #(.COEF_FRAC(COEF_FRAC), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (accept),
        .mute_req (mute_req),
        .gain     (mute_gain)
    );

    volctl_mac #(.DATA_W(DATA_W), .COEF_FRAC(COEF_FRAC)) u_mac (
        .op_a   (mac_a),
        .op_b   (mac_b),
        .result (mac_res)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_GAIN;
            ST_GAIN:  state_d = ST_LEFT;
            ST_LEFT:  state_d = ST_RIGHT;
            ST_RIGHT: state_d = ST_IDLE;
        endcase
    end

    // Operand select for the shared multiplier
    always_comb begin
        mac_a = '0;
        mac_b = '0;
        unique case (state_q)
            ST_IDLE:  begin mac_a = '0; mac_b = '0; end
            ST_GAIN:  begin mac_a = $signed({{PAD_W{1'b0}}, coef_q}); mac_b = mg_q; end
            ST_LEFT:  begin mac_a = {smp_l_q[DATA_W-1], smp_l_q}; mac_b = eff_q; end
            ST_RIGHT: begin mac_a = {smp_r_q[DATA_W-1], smp_r_q}; mac_b = eff_q; end
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_q      <= '0;
            mg_q        <= '0;
            eff_q       <= '0;
            smp_l_q     <= '0;
            smp_r_q     <= '0;
            left_hold_q <= '0;
            res_valid   <= 1'b0;
            res_left    <= '0;
            res_right   <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        coef_q  <= table_coef;
                        mg_q    <= mute_gain;
                        smp_l_q <= smp_left;
                        smp_r_q <= smp_right;
                    end
                end
                ST_GAIN:  eff_q       <= mac_res[COEF_W-1:0];
                ST_LEFT:  left_hold_q <= mac_res;
                ST_RIGHT: begin
                    res_left  <= left_hold_q;
                    res_right <= mac_res;
                    res_valid <= 1'b1;
                end
            endcase
        end
    end

    // R4: the result strobe lasts one cycle
    assert_out_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4: results hold between strobes
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_left) && $stable(res_right)));

    // R8: the mute factor does not move while a sample is in flight
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mute_gain));

endmodule

// File: tb/stereo_vol_mute_tb.sv
module stereo_vol_mute_tb_top;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic signed [19:0]  smp_left = '0;
    logic signed [19:0]  smp_right = '0;
    logic [5:0]          atten_code = '0;
    logic                mute_req = 1'b0;
    logic                res_valid;
    logic signed [19:0]  res_left;
    logic signed [19:0]  res_right;

    int checks = 0;
    int fails  = 0;
    int mg_model = 32768;
    logic signed [19:0] last_l, last_r;

    always #5 clk = ~clk;

    stereo_vol_mute dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_left   (smp_left),
        .smp_right  (smp_right),
        .atten_code (atten_code),
        .mute_req   (mute_req),
        .res_valid  (res_valid),
        .res_left   (res_left),
        .res_right  (res_right)
    );

    function automatic longint coef_ref(input int n);
        if (n <= 1) return 32768;
        if (n >= 62) return 0;
        return longint'($rtoi($pow(10.0, -(n - 1) / 20.0) * 32768.0 + 0.5));
    endfunction

    function automatic longint scale_ref(input longint s, input longint g);
        longint p;
        p = (s * g + 16384) >>> 15;
        if (p > 524287) p = 524287;
        if (p < -524288) p = -524288;
        return p;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One sample through the block, checked against the model
    task automatic send(input string req, input int l, input int r, input int code, input bit mute);
        longint eff;
        logic early;
        eff = (coef_ref(code) * longint'(mg_model) + 16384) >>> 15;
        @(negedge clk);
        smp_valid  = 1'b1;
        smp_left   = 20'(l);
        smp_right  = 20'(r);
        atten_code = 6'(code);
        mute_req   = mute;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        early = res_valid;
        @(negedge clk);
        check({req, " latency"}, {early, res_valid}, 2'b01);
        check({req, " left"}, res_left, scale_ref(l, eff));
        check({req, " right"}, res_right, scale_ref(r, eff));
        last_l = res_left;
        last_r = res_right;
        if (mute) mg_model = (mg_model >= 2048) ? mg_model - 2048 : 0;
        else      mg_model = (mg_model + 2048 > 32768) ? 32768 : mg_model + 2048;
    endtask

    task automatic t_reset_R9();
        check("R9 res_valid", res_valid, 0);
        check("R9 res_left", res_left, 0);
        check("R9 res_right", res_right, 0);
        send("R9 unity after reset", 1000, -1000, 0, 1'b0);
    endtask

    task automatic t_unity_R1();
        send("R1 code0", 524287, -524288, 0, 1'b0);
        check("R1 code0 passthrough", last_l, 524287);
        send("R1 code1", -524288, 12345, 1, 1'b0);
        check("R1 code1 passthrough", last_r, 12345);
    endtask

    task automatic t_steps_R2();
        send("R2 code2", 300001, -300001, 2, 1'b0);
        send("R2 code3", -1, 1, 3, 1'b0);
        send("R2 code7", 524287, -524288, 7, 1'b0);
        send("R2 code11", 77777, -3, 11, 1'b0);
        send("R2 code21", 262144, -262144, 21, 1'b0);
        check("R2 -20dB value", last_l, 26216);
        send("R2 code41", 500000, -500000, 41, 1'b0);
        send("R2 code61", 524287, -524288, 61, 1'b0);
        check("R2 -60dB value", last_l, 528);
    endtask

    task automatic t_silence_R3();
        send("R3 code62", 524287, -524288, 62, 1'b0);
        check("R3 code62 zero", last_l, 0);
        send("R3 code63", -524288, 524287, 63, 1'b0);
        check("R3 code63 zero", last_r, 0);
    endtask

    task automatic t_hold_R4();
        logic signed [19:0] hl;
        hl = res_left;
        repeat (6) @(negedge clk);
        check("R4 hold", res_left, hl);
        check("R4 no strobe while idle", res_valid, 0);
    endtask

    task automatic t_mute_R5();
        for (int k = 0; k < 18; k++) send("R5 ramp down", 262144, -262144, 0, 1'b1);
        check("R5 silent after ramp", last_l, 0);
        check("R5 gain model at zero", mg_model, 0);
    endtask

    task automatic t_unmute_R6();
        for (int k = 0; k < 5; k++) send("R6 partial up", 262144, 100000, 0, 1'b0);
        for (int k = 0; k < 3; k++) send("R6 partial down", 262144, 100000, 0, 1'b1);
        for (int k = 0; k < 16; k++) send("R6 ramp up", 262144, 100000, 0, 1'b0);
        check("R6 back at unity", last_l, 262144);
    endtask

    task automatic t_boundary_R7();
        longint eff;
        eff = (coef_ref(11) * longint'(mg_model) + 16384) >>> 15;
        @(negedge clk);
        smp_valid = 1'b1; smp_left = 20'sd400000; smp_right = -20'sd400000;
        atten_code = 6'd11; mute_req = 1'b0;
        @(negedge clk);
        smp_valid = 1'b0; atten_code = 6'd63; mute_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 strobe", res_valid, 1);
        check("R7 code held at accept", res_left, scale_ref(400000, eff));
        mg_model = 32768;
        send("R7 next sample unmuted", 1000, 2000, 0, 1'b0);
    endtask

    task automatic t_busy_R8();
        int seen;
        seen = 0;
        @(negedge clk);
        smp_valid = 1'b1; smp_left = 20'sd5000; smp_right = 20'sd6000;
        atten_code = 6'd0; mute_req = 1'b0;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        smp_valid = 1'b1; smp_left = 20'sd9; mute_req = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; mute_req = 1'b0;
        @(negedge clk);
        check("R8 first result", res_left, 5000);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (res_valid) seen++;
        end
        check("R8 no extra result", seen, 0);
        send("R8 ramp not stepped", 262144, 262144, 0, 1'b0);
        check("R8 still unity", last_l, 262144);
    endtask

    task automatic t_same_edge();
        send("R5 code and mute on one edge", 300000, -300000, 7, 1'b1);
        send("R5 following stepped gain", 300000, -300000, 7, 1'b1);
        for (int k = 0; k < 2; k++) send("R6 recover", 1, 1, 7, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R9();
        t_unity_R1();
        t_steps_R2();
        t_silence_R3();
        t_hold_R4();
        t_mute_R5();
        t_unmute_R6();
        t_boundary_R7();
        t_busy_R8();
        t_same_edge();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule